// File: doc/BRIEF.md
# CAN Message Buffer Transmit Scheduler

This block decides which of a bank of CAN message buffers may be sent next and hands that choice to an external bit-level protocol engine. Each buffer has a set of control bits: enable, send request, frame-kind select (data or remote), hold-for-remote, a captured remote-request flag, a sent flag and an interrupt enable. Each buffer also has a 4-bit length code. A single global stop bit gates all traffic. It is set out of reset and released by writing it to zero.

Software changes one field of one buffer per cycle through a small write port. A separate input reports that a remote frame has arrived for a given buffer. The scheduler offers the lowest-numbered eligible buffer to the engine, together with its frame kind and length code. The engine accepts the offer with a one-cycle acknowledge and later reports completion with a one-cycle done pulse. On completion the scheduler clears the send request and the captured remote flag of that buffer, sets its sent flag, and raises the interrupt line if that buffer's interrupt enable is set. The state vectors are brought out as outputs so that software and the bench can observe them.

Top module: `can_tx_sched`

## Requirements
- R1: A buffer whose enable bit (field code 0) is 0 is never offered to the engine (`tx_req_o` stays 0 for it).
- R2: A length code above 8 (field code 5) sets that buffer's bit in `dlc_bad_o`, and the buffer is never offered. Codes 0 to 8 are legal.
- R3: When offering a buffer, `tx_idx_o` carries the buffer index, `tx_rtr_o` carries its frame-kind bit (field code 2; 0 = data, 1 = remote) and `tx_dlc_o` carries its stored length code.
- R4: A data request (send request = 1, field code 1, with frame kind 0) whose hold-for-remote bit (field code 3) is 0 is offered in the cycle after the last write that makes it eligible.
- R5: A data request whose hold-for-remote bit is 1 is offered only once that buffer's captured remote flag (`rrtr_o`) is 1.
- R6: A remote request (frame kind 1) whose hold-for-remote bit is 1 is never offered, even when its captured remote flag is set.
- R7: When the engine signals done, the active buffer's bit in `tc_o` becomes 1. `irq_o` is the OR over all buffers of sent AND interrupt enable (field code 4). Writing field code 6 with `cfg_val[0]`=1 clears the sent flag.
- R8: The stop bit (`halt_o`, field code 7 written through `cfg_val[0]`) is 1 after reset. While it is 1, no offer is made.
- R9: A remote-arrival indication for a buffer whose enable bit is 0 leaves that buffer's `rrtr_o` bit at 0.
- R10: When several buffers are eligible, the lowest index is offered first. On done, the chosen buffer's `treq_o` and `rrtr_o` bits return to 0.
- R11: If software clears a send request before the engine acknowledges the offer, `tx_req_o` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_field | input | 3 | Field code: 0 enable, 1 request, 2 frame kind, 3 hold, 4 irq enable, 5 length, 6 sent clear, 7 stop |
| cfg_idx | input | 3 | Buffer addressed by the write |
| cfg_val | input | 4 | Write value (bit 0 for one-bit fields) |
| rx_rtr_hit | input | 1 | Remote frame arrived for `rx_rtr_idx` |
| rx_rtr_idx | input | 3 | Buffer matched by the arriving remote frame |
| tx_req_o | output | 1 | Offer pending to the engine |
| tx_idx_o | output | 3 | Offered buffer index |
| tx_rtr_o | output | 1 | Offered frame kind (1 = remote) |
| tx_dlc_o | output | 4 | Offered length code |
| eng_ack | input | 1 | Engine accepts the current offer |
| eng_done | input | 1 | Engine finished the accepted frame |
| irq_o | output | 1 | Completion interrupt |
| halt_o | output | 1 | Global stop bit |
| valid_o | output | 8 | Enable bits |
| treq_o | output | 8 | Send request bits |
| rrtr_o | output | 8 | Captured remote flags |
| tc_o | output | 8 | Sent flags |
| dlc_bad_o | output | 8 | Illegal length code flags |

## Verification
The bench targets the eligibility corners. A held data buffer must stay silent until a remote arrival is captured, and a held remote buffer must stay silent for good. A design that mixed these up would either send a response too early or send a remote frame it was told to hold back. Length code 9 must be refused while length codes 8 and 0 pass, so an off-by-one limit check shows up as a missing or extra offer. The bench also sets up two simultaneous eligible buffers to expose a wrong priority order. It clears a request before acknowledgment to catch a latched offer, and it sends a remote arrival to a disabled buffer to catch a flag captured when it should be ignored.

// File: rtl/can_tx_sched_pkg.sv
// Package: shared field codes and helper constants for the transmit scheduler.
// Assumes a 3-bit field selector on the configuration write port.
package can_tx_sched_pkg;

    typedef enum logic [2:0] {
        FLD_VALID = 3'd0,
        FLD_TREQ  = 3'd1,
        FLD_RTR   = 3'd2,
        FLD_HOLD  = 3'd3,
        FLD_TIE   = 3'd4,
        FLD_DLC   = 3'd5,
        FLD_TCCLR = 3'd6,
        FLD_HALT  = 3'd7
    } fld_e;

    localparam int unsigned DLC_MAX = 8;

endpackage

// File: rtl/can_txb_slot.sv
// Module: one message buffer's control state and its eligibility decision.
// Assumes at most one field write per cycle. Within a cycle a completion
// overrides a software write to the same bits.
module can_txb_slot
    import can_tx_sched_pkg::*;
#(
    parameter int unsigned DLCW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [2:0]      field,
    input  logic [DLCW-1:0] val,
    input  logic            rx_hit,
    input  logic            done_hit,
    output logic            valid,
    output logic            treq,
    output logic            rtr,
    output logic            hold,
    output logic            tie,
    output logic            rrtr,
    output logic            tc,
    output logic [DLCW-1:0] dlc,
    output logic            dlc_bad,
    output logic            elig
);

    // Per-buffer control registers updated by writes, arrivals and completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            treq  <= 1'b0;
            rtr   <= 1'b0;
            hold  <= 1'b0;
            tie   <= 1'b0;
            rrtr  <= 1'b0;
            tc    <= 1'b0;
            dlc   <= '0;
        end else begin
            if (wr) begin
                case (fld_e'(field))
                    FLD_VALID: valid <= val[0];
                    FLD_TREQ:  treq  <= val[0];
                    FLD_RTR:   rtr   <= val[0];
                    FLD_HOLD:  hold  <= val[0];
                    FLD_TIE:   tie   <= val[0];
                    FLD_DLC:   dlc   <= val;
                    FLD_TCCLR: if (val[0]) tc <= 1'b0;
                    default: ;
                endcase
            end
            if (rx_hit && valid) rrtr <= 1'b1;
            if (done_hit) begin
                treq <= 1'b0;
                rrtr <= 1'b0;
                tc   <= 1'b1;
            end
        end
    end

    // Length legality and the eligibility rule for data and remote requests.
    always_comb begin
        dlc_bad = (dlc > DLCW'(DLC_MAX));
        elig    = valid && treq && !dlc_bad &&
                  (rtr ? !hold : (!hold || rrtr));
    end

endmodule

// File: rtl/can_txb_pick.sv
// Module: lowest-index-first selector over the eligibility vector.
// Assumes the index width is wide enough to hold NBUF-1.
module can_txb_pick #(
    parameter int unsigned NBUF = 8,
    localparam int unsigned IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0] elig,
    output logic            any,
    output logic [IW-1:0]   idx
);

    // Scan from the top so the lowest set bit is the last one assigned.
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/can_tx_sched.sv
// Module: transmit scheduler top. It holds the per-buffer slots and the stop
// bit, offers one buffer at a time to the protocol engine, and tracks the
// accepted buffer until done. Assumes eng_ack arrives only while tx_req_o is
// high and eng_done arrives only after an acknowledge. Stray pulses are ignored.
module can_tx_sched
    import can_tx_sched_pkg::*;
#(
    parameter int unsigned NBUF = 8,
    parameter int unsigned DLCW = 4,
    localparam int unsigned IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_field,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [DLCW-1:0] cfg_val,
    input  logic            rx_rtr_hit,
    input  logic [IW-1:0]   rx_rtr_idx,
    output logic            tx_req_o,
    output logic [IW-1:0]   tx_idx_o,
    output logic            tx_rtr_o,
    output logic [DLCW-1:0] tx_dlc_o,
    input  logic            eng_ack,
    input  logic            eng_done,
    output logic            irq_o,
    output logic            halt_o,
    output logic [NBUF-1:0] valid_o,
    output logic [NBUF-1:0] treq_o,
    output logic [NBUF-1:0] rrtr_o,
    output logic [NBUF-1:0] tc_o,
    output logic [NBUF-1:0] dlc_bad_o
);

    logic                       halt_q;
    logic                       busy_q;
    logic [IW-1:0]              cur_q;
    logic [NBUF-1:0]            rtr_w;
    logic [NBUF-1:0]            hold_w;
    logic [NBUF-1:0]            tie_w;
    logic [NBUF-1:0]            elig_w;
    logic [NBUF-1:0][DLCW-1:0]  dlc_w;
    logic                       any_w;
    logic [IW-1:0]              pick_w;
    logic                       done_ev;

    assign done_ev = busy_q && eng_done;

    // One slot per buffer; each sees only its own write, arrival and completion.
    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        can_txb_slot #(.DLCW(DLCW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (cfg_we && (cfg_idx == IW'(g)) && (cfg_field != FLD_HALT)),
            .field    (cfg_field),
            .val      (cfg_val),
            .rx_hit   (rx_rtr_hit && (rx_rtr_idx == IW'(g))),
            .done_hit (done_ev && (cur_q == IW'(g))),
            .valid    (valid_o[g]),
            .treq     (treq_o[g]),
            .rtr      (rtr_w[g]),
            .hold     (hold_w[g]),
            .tie      (tie_w[g]),
            .rrtr     (rrtr_o[g]),
            .tc       (tc_o[g]),
            .dlc      (dlc_w[g]),
            .dlc_bad  (dlc_bad_o[g]),
            .elig     (elig_w[g])
        );
    end

    can_txb_pick #(.NBUF(NBUF)) u_pick (
        .elig (elig_w),
        .any  (any_w),
        .idx  (pick_w)
    );

    // Global stop bit: set by reset, changed only by its own field write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
        end else if (cfg_we && (cfg_field == FLD_HALT)) begin
            halt_q <= cfg_val[0];
        end
    end

    // Offer drive: combinational, so a withdrawn request drops at once.
    always_comb begin
        tx_req_o = !busy_q && !halt_q && any_w;
        tx_idx_o = pick_w;
        tx_rtr_o = rtr_w[pick_w];
        tx_dlc_o = dlc_w[pick_w];
    end

    // Engine handshake tracker: latches the accepted buffer until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (!busy_q) begin
            if (tx_req_o && eng_ack) begin
                busy_q <= 1'b1;
                cur_q  <= pick_w;
            end
        end else if (eng_done) begin
            busy_q <= 1'b0;
        end
    end

    // Interrupt and stop-bit outputs.
    always_comb begin
        irq_o  = |(tc_o & tie_w);
        halt_o = halt_q;
    end

endmodule

// File: rtl/can_tx_sched_chk.sv
// Checker: temporal properties of the scheduler, bound onto the top module.
module can_tx_sched_chk #(
    parameter int unsigned NBUF = 8,
    parameter int unsigned DLCW = 4,
    localparam int unsigned IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_req_o,
    input logic [IW-1:0]   tx_idx_o,
    input logic            tx_rtr_o,
    input logic [DLCW-1:0] tx_dlc_o,
    input logic            halt_o,
    input logic [NBUF-1:0] valid_o,
    input logic [NBUF-1:0] treq_o,
    input logic [NBUF-1:0] rrtr_o,
    input logic [NBUF-1:0] tc_o,
    input logic [NBUF-1:0] hold_w,
    input logic            busy_q,
    input logic [IW-1:0]   cur_q,
    input logic            eng_done,
    input logic            rx_rtr_hit,
    input logic [IW-1:0]   rx_rtr_idx
);

    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> valid_o[tx_idx_o]);

    p_dlc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> (tx_dlc_o <= DLCW'(8)));

    p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o && !tx_rtr_o && hold_w[tx_idx_o]) |-> rrtr_o[tx_idx_o]);

    p_noremote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o && tx_rtr_o) |-> !hold_w[tx_idx_o]);

    p_sent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && eng_done) |=> tc_o[$past(cur_q)]);

    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !tx_req_o);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rtr_hit && !valid_o[rx_rtr_idx] && !rrtr_o[rx_rtr_idx])
        |=> !rrtr_o[$past(rx_rtr_idx)]);

    p_withdraw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> treq_o[tx_idx_o]);

endmodule

bind can_tx_sched can_tx_sched_chk #(.NBUF(NBUF), .DLCW(DLCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req_o   (tx_req_o),
    .tx_idx_o   (tx_idx_o),
    .tx_rtr_o   (tx_rtr_o),
    .tx_dlc_o   (tx_dlc_o),
    .halt_o     (halt_o),
    .valid_o    (valid_o),
    .treq_o     (treq_o),
    .rrtr_o     (rrtr_o),
    .tc_o       (tc_o),
    .hold_w     (hold_w),
    .busy_q     (busy_q),
    .cur_q      (cur_q),
    .eng_done   (eng_done),
    .rx_rtr_hit (rx_rtr_hit),
    .rx_rtr_idx (rx_rtr_idx)
);

// File: tb/can_tx_sched_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected offers; an engine model pops and compares.
module can_tx_sched_tb_top;

    localparam int NBUF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_field = '0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_val = '0;
    logic       rx_rtr_hit = 1'b0;
    logic [2:0] rx_rtr_idx = '0;
    logic       eng_ack = 1'b0;
    logic       eng_done = 1'b0;
    logic       tx_req_o, tx_rtr_o, irq_o, halt_o;
    logic [2:0] tx_idx_o;
    logic [3:0] tx_dlc_o;
    logic [NBUF-1:0] valid_o, treq_o, rrtr_o, tc_o, dlc_bad_o;

    typedef struct { int idx; int rtr; int dlc; } exp_t;
    exp_t exp_q[$];

    int  n_checks = 0;
    int  n_fail = 0;
    int  served = 0;
    bit  engine_on = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    can_tx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_idx(cfg_idx), .cfg_val(cfg_val), .rx_rtr_hit(rx_rtr_hit),
        .rx_rtr_idx(rx_rtr_idx), .tx_req_o(tx_req_o), .tx_idx_o(tx_idx_o),
        .tx_rtr_o(tx_rtr_o), .tx_dlc_o(tx_dlc_o), .eng_ack(eng_ack),
        .eng_done(eng_done), .irq_o(irq_o), .halt_o(halt_o), .valid_o(valid_o),
        .treq_o(treq_o), .rrtr_o(rrtr_o), .tc_o(tc_o), .dlc_bad_o(dlc_bad_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int field, input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = 3'(field); cfg_idx = 3'(idx); cfg_val = 4'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input int idx, input int rtr, input int dlc);
        exp_t e;
        e.idx = idx; e.rtr = rtr; e.dlc = dlc;
        exp_q.push_back(e);
    endtask

    // Driver side: let the engine serve n queued offers, then stop it.
    task automatic run_engine(input int n);
        int start;
        start = served;
        engine_on = 1'b1;
        while (served < start + n) @(negedge clk);
        engine_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Monitor and engine model: compare each offer with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (engine_on && tx_req_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected offer idx", int'(tx_idx_o), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(tx_idx_o) == e.idx, "R10 offer index", int'(tx_idx_o), e.idx);
                    check(int'(tx_rtr_o) == e.rtr, "R3 frame kind", int'(tx_rtr_o), e.rtr);
                    check(int'(tx_dlc_o) == e.dlc, "R3 length code", int'(tx_dlc_o), e.dlc);
                end
                eng_ack = 1'b1;
                @(negedge clk);
                eng_ack = 1'b0;
                repeat (2) @(negedge clk);
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
                served++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R8)
        check(halt_o == 1'b1, "R8 stop bit after reset", int'(halt_o), 1);
        check(tx_req_o == 1'b0, "R8 no offer after reset", int'(tx_req_o), 0);
        check(irq_o == 1'b0, "R7 irq after reset", int'(irq_o), 0);

        // Buffer 3 data, length 5, while stopped (R8), then released (R4)
        wr(0, 3, 1); wr(5, 3, 5); wr(1, 3, 1);
        check(tx_req_o == 1'b0, "R8 stopped blocks offer", int'(tx_req_o), 0);
        wr(7, 0, 0);
        check(tx_req_o == 1'b1, "R4 immediate data offer", int'(tx_req_o), 1);
        push(3, 0, 5);
        run_engine(1);
        check(tc_o[3] == 1'b1, "R7 sent flag set", int'(tc_o[3]), 1);
        check(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);
        check(treq_o[3] == 1'b0, "R10 request cleared on done", int'(treq_o[3]), 0);
        wr(4, 3, 1);
        check(irq_o == 1'b1, "R7 irq enabled", int'(irq_o), 1);
        wr(6, 3, 1);
        check(tc_o[3] == 1'b0, "R7 sent flag cleared", int'(tc_o[3]), 0);
        check(irq_o == 1'b0, "R7 irq drops", int'(irq_o), 0);

        // Disabled buffer with request (R1)
        wr(5, 2, 3); wr(1, 2, 1);
        check(tx_req_o == 1'b0, "R1 disabled buffer silent", int'(tx_req_o), 0);

        // Illegal length 9 (R2)
        wr(0, 1, 1); wr(5, 1, 9); wr(1, 1, 1);
        check(dlc_bad_o[1] == 1'b1, "R2 illegal length flagged", int'(dlc_bad_o[1]), 1);
        check(tx_req_o == 1'b0, "R2 illegal length not offered", int'(tx_req_o), 0);

        // Two eligible: buffer 6 remote length 2, buffer 4 data length 0 (R10, R3)
        wr(0, 6, 1); wr(5, 6, 2); wr(2, 6, 1); wr(1, 6, 1);
        wr(0, 4, 1); wr(5, 4, 0); wr(1, 4, 1);
        push(4, 0, 0); push(6, 1, 2);
        run_engine(2);
        check(exp_q.size() == 0, "R10 both served in order", exp_q.size(), 0);

        // Hold-for-remote data on buffer 5, length 8 (R5)
        wr(0, 5, 1); wr(5, 5, 8); wr(3, 5, 1); wr(1, 5, 1);
        check(tx_req_o == 1'b0, "R5 held data waits", int'(tx_req_o), 0);
        @(negedge clk);
        rx_rtr_hit = 1'b1; rx_rtr_idx = 3'd5;
        @(negedge clk);
        rx_rtr_hit = 1'b0;
        check(rrtr_o[5] == 1'b1, "R5 remote captured", int'(rrtr_o[5]), 1);
        check(tx_req_o == 1'b1 && tx_idx_o == 3'd5, "R5 held data released",
              int'(tx_idx_o), 5);
        push(5, 0, 8);
        run_engine(1);
        check(rrtr_o[5] == 1'b0, "R10 remote flag cleared on done", int'(rrtr_o[5]), 0);

        // Held remote request on buffer 0 never offered (R6)
        wr(0, 0, 1); wr(5, 0, 1); wr(2, 0, 1); wr(3, 0, 1); wr(1, 0, 1);
        @(negedge clk);
        rx_rtr_hit = 1'b1; rx_rtr_idx = 3'd0;
        @(negedge clk);
        rx_rtr_hit = 1'b0;
        check(rrtr_o[0] == 1'b1, "R6 flag set yet held", int'(rrtr_o[0]), 1);
        check(tx_req_o == 1'b0, "R6 held remote never offered", int'(tx_req_o), 0);

        // Arrival for disabled buffer 7 ignored (R9)
        @(negedge clk);
        rx_rtr_hit = 1'b1; rx_rtr_idx = 3'd7;
        @(negedge clk);
        rx_rtr_hit = 1'b0;
        check(rrtr_o[7] == 1'b0, "R9 disabled buffer ignores remote", int'(rrtr_o[7]), 0);

        // Withdrawal before acknowledge (R11)
        wr(0, 2, 1);
        check(tx_req_o == 1'b1 && tx_idx_o == 3'd2, "R11 offer present", int'(tx_idx_o), 2);
        wr(1, 2, 0);
        check(tx_req_o == 1'b0, "R11 offer withdrawn", int'(tx_req_o), 0);

        finished = 1'b1;
        report();
    end

endmodule